// File: doc/BRIEF.md
# Voice Buffer Host Handshake

This block is the host-facing access logic for two voice sample buffers: a transmit buffer that an internal producer fills and the host drains, and a receive buffer that the host fills and an internal consumer drains. The host reaches both over an asynchronous parallel bus with an active-low chip select, read strobe, write strobe and an 8-bit address. Every bus input passes through a two-stage synchronizer. A word transfer is complete on the rising (trailing) edge of its strobe.

Each direction has one active-low handshake output. A single mode input picks its meaning for both directions. In frame mode the output is a frame-level flag: low while a whole frame is waiting for the host. In DMA mode it is a per-word request: it goes high on the leading edge of a strobe made under that direction's acknowledge, and it drops low again after the word if more words of the frame remain. Each direction stores data in two banks of `WORDS` words that swap roles at each frame boundary. Overrun and underflow are flagged when the internal side crosses a frame boundary before the host has finished its frame.

Top module: `voxbuf_handshake`

## Requirements
- R1: With `cs_n` low, `addr[7:6]` = 2'b10 selects the transmit buffer, 2'b01 selects the receive buffer, 2'b00 raises `reg_sel`, and 2'b11 selects nothing. `addr[5:0]` has no effect on buffer accesses, and `reg_sel` stays low for the two buffer windows.
- R2: In frame mode (`dma_mode`=0), `tx_flag_n` goes low once the internal side has pushed `WORDS` words. It stays low until the host has completed `WORDS` reads, and then goes high.
- R3: In frame mode, `rx_flag_n` is low after reset and whenever the host-side receive bank is empty. It goes high after `WORDS` host writes, and goes low again when the internal side starts consuming that frame.
- R4: In DMA mode (`dma_mode`=1), `tx_flag_n` is low while a transmit frame is pending. It goes high on the falling edge of `rd_n` while `ack_tx_n` is low. It returns low after the read completes if words remain, and stays high after the last word.
- R5: In DMA mode, `rx_flag_n` is low while the receive bank needs data. It goes high on the falling edge of `wr_n` while `ack_rx_n` is low. It returns low after the write completes if words remain, and stays high after the last word.
- R6: In frame mode the flags do not toggle between the words of a frame.
- R7: `overrun` goes high when the internal side completes a new transmit frame while the host has not yet finished reading the current one. The new frame replaces the old one, and the host restarts at its first word. `overrun` clears when the host completes reading a frame.
- R8: `underflow` goes high when the internal side begins a receive frame (the first `rx_pop` of a frame) before the host has finished writing one. It clears when the host completes writing a frame.
- R9: With `bus8`=1, host reads return zero in bits 15:8, and host writes store zero in bits 15:8.
- R10: The host reads transmit words in the order they were pushed. `rx_pop_data`, valid the cycle after `rx_pop`, returns receive words in the order the host wrote them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus chip select, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| addr | input | 8 | Bus address; top two bits pick the window |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data (current transmit word) |
| ack_tx_n | input | 1 | DMA acknowledge for the transmit buffer |
| ack_rx_n | input | 1 | DMA acknowledge for the receive buffer |
| dma_mode | input | 1 | 0 frame flag, 1 per-word DMA request |
| bus8 | input | 1 | Limit transfers to the low data byte |
| tx_flag_n | output | 1 | Transmit frame flag or DMA request |
| rx_flag_n | output | 1 | Receive frame flag or DMA request |
| reg_sel | output | 1 | Control register window selected |
| tx_push | input | 1 | Internal side writes one transmit word |
| tx_push_data | input | 16 | Internal transmit word |
| rx_pop | input | 1 | Internal side reads one receive word |
| rx_pop_data | output | 16 | Internal receive word, valid one cycle after `rx_pop` |
| overrun | output | 1 | Transmit overrun indication |
| underflow | output | 1 | Receive underflow indication |

## Verification
A wrong word index or bank select in either direction shows up as a wrong value on `rdata` or `rx_pop_data` at the first word of the affected frame. A stuck frame-pending or in-flight state shows up as a handshake output at the wrong level. For a strobe, this is visible within four clocks of the strobe edge, which covers the synchronizer and state latency. A missed or premature frame-boundary decision appears on `overrun`, `underflow` or the flags in the cycle after the push or pop that crosses the boundary. The bench therefore checks data word by word and checks flag levels both inside and after each strobe.

// File: rtl/voxbuf_pkg.sv
package voxbuf_pkg;
  typedef enum logic [1:0] {
    WIN_REG  = 2'b00,
    WIN_RX   = 2'b01,
    WIN_TX   = 2'b10,
    WIN_NONE = 2'b11
  } win_e;

  function automatic win_e decode_win(input logic [1:0] top);
    case (top)
      2'b00:   return WIN_REG;
      2'b01:   return WIN_RX;
      2'b10:   return WIN_TX;
      default: return WIN_NONE;
    endcase
  endfunction
endpackage

// File: rtl/voxbuf_bus_if.sv
module voxbuf_bus_if
  import voxbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ack_tx_n,
  input  logic          ack_rx_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          bus8,
  output logic          tx_rd_fall,
  output logic          tx_rd_done,
  output logic          rx_wr_fall,
  output logic          rx_wr_done,
  output logic [DW-1:0] wr_word,
  output logic          reg_sel
);
  localparam int SW = 5 + AW + DW;

  logic [SW-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= {cs_n, rd_n, wr_n, ack_tx_n, ack_rx_n, addr, wdata};
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  logic          cs2, rd2, wr2, at2, ar2;
  logic          cs3, rd3, wr3, at3, ar3;
  logic [AW-1:0] a2, a3;
  logic [DW-1:0] d2, d3;
  assign {cs2, rd2, wr2, at2, ar2, a2, d2} = s2_q;
  assign {cs3, rd3, wr3, at3, ar3, a3, d3} = s3_q;

  logic unused_bits;
  assign unused_bits = ^{d2, a2[AW-3:0], a3[AW-3:0]};

  win_e w_now, w_prev;
  assign w_now  = decode_win(a2[AW-1:AW-2]);
  assign w_prev = decode_win(a3[AW-1:AW-2]);

  logic tx_sel_now, rx_sel_now, tx_sel_prev, rx_sel_prev;
  assign tx_sel_now  = (!cs2 && w_now  == WIN_TX) || !at2;
  assign rx_sel_now  = (!cs2 && w_now  == WIN_RX) || !ar2;
  assign tx_sel_prev = (!cs3 && w_prev == WIN_TX) || !at3;
  assign rx_sel_prev = (!cs3 && w_prev == WIN_RX) || !ar3;

  assign tx_rd_fall = rd3 && !rd2 && tx_sel_now;
  assign tx_rd_done = !rd3 && rd2 && tx_sel_prev;
  assign rx_wr_fall = wr3 && !wr2 && rx_sel_now;
  assign rx_wr_done = !wr3 && wr2 && rx_sel_prev;
  assign reg_sel    = !cs2 && w_now == WIN_REG;

  assign wr_word = bus8 ? {{(DW-8){1'b0}}, d3[7:0]} : d3;

  // R1: a register-window select never coincides with a transmit read edge through chip select
  p_reg_excl_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && at2) |-> !tx_rd_fall);
endmodule

// File: rtl/voxbuf_tx_path.sv
module voxbuf_tx_path #(
  parameter int DW    = 16,
  parameter int WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          rd_fall,
  input  logic          rd_done,
  output logic [DW-1:0] host_word,
  output logic          flag_n,
  output logic          overrun
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic [DW-1:0] mem [2][WORDS];
  logic          int_bank_q, int_bank_d;
  logic [IW-1:0] int_idx_q, int_idx_d, host_idx_q, host_idx_d;
  logic          avail_q, avail_d, infl_q, infl_d, ovr_q, ovr_d;

  always_comb begin
    int_bank_d = int_bank_q;
    int_idx_d  = int_idx_q;
    host_idx_d = host_idx_q;
    avail_d    = avail_q;
    infl_d     = infl_q;
    ovr_d      = ovr_q;
    if (rd_fall && avail_q) infl_d = 1'b1;
    if (rd_done && avail_q) begin
      infl_d = 1'b0;
      if (host_idx_q == LAST) begin
        avail_d    = 1'b0;
        host_idx_d = '0;
        ovr_d      = 1'b0;
      end else begin
        host_idx_d = host_idx_q + 1'b1;
      end
    end
    if (push) begin
      if (int_idx_q == LAST) begin
        int_idx_d  = '0;
        int_bank_d = !int_bank_q;
        avail_d    = 1'b1;
        host_idx_d = '0;
        infl_d     = 1'b0;
        if (avail_q) ovr_d = 1'b1;
      end else begin
        int_idx_d = int_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_bank_q <= 1'b0;
      int_idx_q  <= '0;
      host_idx_q <= '0;
      avail_q    <= 1'b0;
      infl_q     <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      int_bank_q <= int_bank_d;
      int_idx_q  <= int_idx_d;
      host_idx_q <= host_idx_d;
      avail_q    <= avail_d;
      infl_q     <= infl_d;
      ovr_q      <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[int_bank_q][int_idx_q] <= push_data;
  end

  assign host_word = mem[!int_bank_q][host_idx_q];
  assign flag_n    = dma_mode ? !(avail_q && !infl_q) : !avail_q;
  assign overrun   = ovr_q;

  // R7: finishing a frame while the host still holds one raises overrun
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && int_idx_q == LAST && avail_q) |=> overrun);
  // R4: a strobe leading edge under acknowledge releases the request
  p_req_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && rd_fall && avail_q && !push && !rd_done) |=> (flag_n || !dma_mode));
  // R2: the last host read of a frame ends the pending state
  p_frame_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && avail_q && host_idx_q == LAST && !push) |=> (!dma_mode |-> flag_n));
endmodule

// File: rtl/voxbuf_rx_path.sv
module voxbuf_rx_path #(
  parameter int DW    = 16,
  parameter int WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_mode,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  input  logic          wr_fall,
  input  logic          wr_done,
  input  logic [DW-1:0] wr_word,
  output logic          flag_n,
  output logic          underflow
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic [DW-1:0] mem [2][WORDS];
  logic          int_bank_q, int_bank_d;
  logic [IW-1:0] int_idx_q, int_idx_d, host_idx_q, host_idx_d;
  logic          ready_q, ready_d, infl_q, infl_d, unf_q, unf_d;
  logic          host_we, rd_bank;
  logic [DW-1:0] pop_q;

  assign host_we = wr_done && !ready_q;
  assign rd_bank = (int_idx_q == '0 && ready_q) ? !int_bank_q : int_bank_q;

  always_comb begin
    int_bank_d = int_bank_q;
    int_idx_d  = int_idx_q;
    host_idx_d = host_idx_q;
    ready_d    = ready_q;
    infl_d     = infl_q;
    unf_d      = unf_q;
    if (wr_fall && !ready_q) infl_d = 1'b1;
    if (host_we) begin
      infl_d = 1'b0;
      if (host_idx_q == LAST) begin
        ready_d    = 1'b1;
        host_idx_d = '0;
        unf_d      = 1'b0;
      end else begin
        host_idx_d = host_idx_q + 1'b1;
      end
    end
    if (pop) begin
      if (int_idx_q == '0) begin
        if (ready_q) begin
          int_bank_d = !int_bank_q;
          ready_d    = 1'b0;
        end else begin
          unf_d = 1'b1;
        end
      end
      int_idx_d = (int_idx_q == LAST) ? '0 : int_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_bank_q <= 1'b0;
      int_idx_q  <= '0;
      host_idx_q <= '0;
      ready_q    <= 1'b0;
      infl_q     <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      int_bank_q <= int_bank_d;
      int_idx_q  <= int_idx_d;
      host_idx_q <= host_idx_d;
      ready_q    <= ready_d;
      infl_q     <= infl_d;
      unf_q      <= unf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (host_we) mem[!int_bank_q][host_idx_q] <= wr_word;
    if (pop)     pop_q <= mem[rd_bank][int_idx_q];
  end

  assign pop_data  = pop_q;
  assign flag_n    = dma_mode ? (ready_q || infl_q) : ready_q;
  assign underflow = unf_q;

  // R8: starting a frame with no completed host frame raises underflow
  p_underflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && int_idx_q == '0 && !ready_q) |=> underflow);
  // R3: the last host write of a frame releases the frame flag
  p_frame_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_idx_q == LAST && !pop) |=> flag_n);
endmodule

// File: rtl/voxbuf_handshake.sv
module voxbuf_handshake #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ack_tx_n,
  input  logic          ack_rx_n,
  input  logic          dma_mode,
  input  logic          bus8,
  output logic          tx_flag_n,
  output logic          rx_flag_n,
  output logic          reg_sel,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic          overrun,
  output logic          underflow
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic          tx_rd_fall, tx_rd_done, rx_wr_fall, rx_wr_done;
  logic [DW-1:0] wr_word, host_word;

  voxbuf_bus_if #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n_s), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ack_tx_n(ack_tx_n), .ack_rx_n(ack_rx_n), .addr(addr), .wdata(wdata),
    .bus8(bus8), .tx_rd_fall(tx_rd_fall), .tx_rd_done(tx_rd_done),
    .rx_wr_fall(rx_wr_fall), .rx_wr_done(rx_wr_done), .wr_word(wr_word),
    .reg_sel(reg_sel)
  );

  voxbuf_tx_path #(.DW(DW), .WORDS(WORDS)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .dma_mode(dma_mode), .push(tx_push),
    .push_data(tx_push_data), .rd_fall(tx_rd_fall), .rd_done(tx_rd_done),
    .host_word(host_word), .flag_n(tx_flag_n), .overrun(overrun)
  );

  voxbuf_rx_path #(.DW(DW), .WORDS(WORDS)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .dma_mode(dma_mode), .pop(rx_pop),
    .pop_data(rx_pop_data), .wr_fall(rx_wr_fall), .wr_done(rx_wr_done),
    .wr_word(wr_word), .flag_n(rx_flag_n), .underflow(underflow)
  );

  // R9: byte mode clears the upper read lanes
  assign rdata = bus8 ? {{(DW-8){1'b0}}, host_word[7:0]} : host_word;
endmodule

// File: tb/voxbuf_handshake_bench.sv
module voxbuf_handshake_bench;
  localparam int WORDS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n, ack_tx_n, ack_rx_n, dma_mode, bus8;
  logic [7:0]  addr;
  logic [15:0] wdata, rdata, tx_push_data, rx_pop_data;
  logic        tx_flag_n, rx_flag_n, reg_sel, tx_push, rx_pop, overrun, underflow;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  voxbuf_handshake #(.AW(8), .DW(16), .WORDS(WORDS)) u_voxbuf_handshake (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack_tx_n(ack_tx_n),
    .ack_rx_n(ack_rx_n), .dma_mode(dma_mode), .bus8(bus8),
    .tx_flag_n(tx_flag_n), .rx_flag_n(rx_flag_n), .reg_sel(reg_sel),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .rx_pop(rx_pop),
    .rx_pop_data(rx_pop_data), .overrun(overrun), .underflow(underflow)
  );

  // address decode vectors: {addr, expected reg_sel}
  localparam logic [8:0] DEC_VEC [6] = '{
    {8'h00, 1'b1}, {8'h3F, 1'b1}, {8'h40, 1'b0},
    {8'h80, 1'b0}, {8'hC0, 1'b0}, {8'h15, 1'b1}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_read(input bit dma, input logic [7:0] a, output logic [15:0] d);
    if (dma) ack_tx_n = 1'b0;
    else begin cs_n = 1'b0; addr = a; end
    wait_cyc(1);
    rd_n = 1'b0;
    wait_cyc(4);
    d = rdata;
    if (dma) check("R4 request high inside strobe", tx_flag_n, 1);
    rd_n = 1'b1;
    wait_cyc(4);
    cs_n = 1'b1; ack_tx_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic rx_write(input bit dma, input logic [7:0] a, input logic [15:0] d);
    if (dma) ack_rx_n = 1'b0;
    else begin cs_n = 1'b0; addr = a; end
    wdata = d;
    wait_cyc(1);
    wr_n = 1'b0;
    wait_cyc(4);
    if (dma) check("R5 request high inside strobe", rx_flag_n, 1);
    wr_n = 1'b1;
    wait_cyc(4);
    cs_n = 1'b1; ack_rx_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic push_frame(input logic [15:0] base);
    for (int i = 0; i < WORDS; i++) begin
      tx_push = 1'b1; tx_push_data = base + 16'(i);
      wait_cyc(1);
    end
    tx_push = 1'b0;
    wait_cyc(1);
  endtask

  task automatic pop_one(output logic [15:0] d);
    rx_pop = 1'b1;
    wait_cyc(1);
    rx_pop = 1'b0;
    d = rx_pop_data;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 8'hFF;
    wdata = '0; ack_tx_n = 1'b1; ack_rx_n = 1'b1; dma_mode = 1'b0; bus8 = 1'b0;
    tx_push = 1'b0; tx_push_data = '0; rx_pop = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);

    // reset state
    check("R2 tx flag after reset", tx_flag_n, 1);
    check("R3 rx flag low after reset (empty)", rx_flag_n, 0);
    check("R7 overrun after reset", overrun, 0);
    check("R8 underflow after reset", underflow, 0);
    check("R1 reg_sel after reset", reg_sel, 0);

    // R1 decode table
    foreach (DEC_VEC[k]) begin
      cs_n = 1'b0; addr = DEC_VEC[k][8:1];
      wait_cyc(3);
      check($sformatf("R1 reg_sel addr=%0h", DEC_VEC[k][8:1]), reg_sel, DEC_VEC[k][0]);
    end
    cs_n = 1'b1; addr = 8'hFF;
    wait_cyc(3);

    // R2/R6/R10 frame mode transmit, varying low address bits (R1)
    push_frame(16'h1100);
    check("R2 tx flag low after frame", tx_flag_n, 0);
    for (int i = 0; i < WORDS; i++) begin
      tx_read(1'b0, 8'h80 | 8'(i * 5), d);
      check($sformatf("R10 tx word %0d", i), d, 16'h1100 + 16'(i));
      if (i < WORDS - 1) check("R6 tx flag steady between words", tx_flag_n, 0);
    end
    check("R2 tx flag high after last read", tx_flag_n, 1);

    // R7 overrun
    push_frame(16'h2200);
    tx_read(1'b0, 8'h80, d); check("R10 frame B word 0", d, 16'h2200);
    tx_read(1'b0, 8'hBF, d); check("R10 frame B word 1", d, 16'h2201);
    check("R7 no overrun before next frame", overrun, 0);
    push_frame(16'h3300);
    check("R7 overrun raised", overrun, 1);
    for (int i = 0; i < WORDS; i++) begin
      tx_read(1'b0, 8'h80, d);
      check($sformatf("R7 replacement frame word %0d", i), d, 16'h3300 + 16'(i));
      if (i == WORDS - 2) check("R7 overrun held mid-frame", overrun, 1);
    end
    check("R7 overrun cleared after full read", overrun, 0);
    check("R2 tx flag high after replacement frame", tx_flag_n, 1);

    // R3 frame mode receive
    for (int i = 0; i < WORDS; i++) begin
      rx_write(1'b0, 8'h40 | 8'(i), 16'h4400 + 16'(i));
      if (i < WORDS - 1) check("R6 rx flag steady between words", rx_flag_n, 0);
    end
    check("R3 rx flag high after frame written", rx_flag_n, 1);
    for (int i = 0; i < WORDS; i++) begin
      pop_one(d);
      check($sformatf("R10 rx word %0d", i), d, 16'h4400 + 16'(i));
      if (i == 0) check("R3 rx flag low once frame consumed", rx_flag_n, 0);
    end

    // R8 underflow
    pop_one(d);
    check("R8 underflow raised", underflow, 1);
    for (int i = 1; i < WORDS; i++) pop_one(d);
    for (int i = 0; i < WORDS; i++) rx_write(1'b0, 8'h7F, 16'h5500 + 16'(i));
    check("R8 underflow cleared by full write", underflow, 0);
    for (int i = 0; i < WORDS; i++) begin
      pop_one(d);
      if (i == 0) check("R10 rx after underflow word 0", d, 16'h5500);
    end

    // R4 DMA transmit
    dma_mode = 1'b1;
    wait_cyc(1);
    push_frame(16'h6600);
    check("R4 request low on frame", tx_flag_n, 0);
    for (int i = 0; i < WORDS; i++) begin
      tx_read(1'b1, 8'hFF, d);
      check($sformatf("R4 DMA tx word %0d", i), d, 16'h6600 + 16'(i));
      check("R4 request level after word", tx_flag_n, (i < WORDS - 1) ? 0 : 1);
    end

    // R5 DMA receive
    check("R5 request low when empty", rx_flag_n, 0);
    for (int i = 0; i < WORDS; i++) begin
      rx_write(1'b1, 8'hFF, 16'h7700 + 16'(i));
      check("R5 request level after word", rx_flag_n, (i < WORDS - 1) ? 0 : 1);
    end
    for (int i = 0; i < WORDS; i++) begin
      pop_one(d);
      if (i == 3) check("R5 DMA rx word 3", d, 16'h7703);
    end

    // R9 byte mode
    dma_mode = 1'b0; bus8 = 1'b1;
    wait_cyc(1);
    for (int i = 0; i < WORDS; i++) rx_write(1'b0, 8'h40, 16'hA5C0 + 16'(i));
    for (int i = 0; i < WORDS; i++) begin
      pop_one(d);
      if (i == 2) check("R9 write upper byte zero", d, 16'h00C2);
    end
    push_frame(16'h7E80);
    tx_read(1'b0, 8'h80, d);
    check("R9 read upper byte zero", d, 16'h0080);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule